// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a heartbeat line driven by a processor and pulls its active-low watchdog output down when the line has not changed level for a programmed number of clock cycles. A transition in either direction on the heartbeat restarts the count. The output is meant to feed a nonmaskable interrupt input or a manual reset input, so that a stalled program is noticed and handled.

The heartbeat is treated as asynchronous. It passes through a two-flop synchronizer, and a registered copy of the synchronized level is compared with the level itself to find edges. The active-low reset from the system reset generator clears the count, and the timeout window opens only once that reset is released. A supply-good flag that drops pulls the output low whatever the count is. An enable flag stands for the "heartbeat line is connected" detection. When it is low, the count is held at zero and the output follows only the supply flag, so the output becomes a plain low-line indicator. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `wdt_edge_watchdog`

## Requirements
- R1: With the enable high, the supply good and no heartbeat edge, `wdo_n` is high for the first TIMEOUT-1 rising clock edges after the count starts from zero, and goes low after the TIMEOUT-th edge.
- R2: A rising or a falling heartbeat transition clears the count. While transitions keep arriving closer together than the timeout, `wdo_n` stays high.
- R3: Once the timeout has been reached, the count saturates and `wdo_n` stays low until a heartbeat edge, a reset or a disable clears it.
- R4: While `supply_ok` is low, `wdo_n` is low, whatever the count or the enable. This takes effect in the same cycle, without waiting for a clock edge.
- R5: While `mon_en` is low, the count is held at zero, so `wdo_n` equals `supply_ok`.
- R6: While `rst_n` is low, the count is zero and `wdo_n` equals `supply_ok`, asynchronously. After `rst_n` rises, the timeout of R1 starts counting from zero.
- R7: When `mon_en` returns high, counting restarts from zero, with the same timing as R1.
- R8: A heartbeat change applied between clock edges clears the count on the third rising edge after it, so a `wdo_n` that is low rises at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the timeout is counted in its cycles |
| rst_n | input | 1 | Active-low reset from the reset generator; clears the count asynchronously |
| hb_in | input | 1 | Asynchronous heartbeat line from the processor |
| mon_en | input | 1 | High when the heartbeat line is connected and monitoring is wanted |
| supply_ok | input | 1 | High while the supply is above the reset threshold |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The checker assumes that `supply_ok` and `mon_en` are synchronous levels. It also assumes that any heartbeat edge reaching the counter is visible one cycle earlier as a toggle of the synchronized level. This holds only if the heartbeat holds each level for at least one clock cycle, which the stimulus ensures by changing `hb_in` only on falling clock edges and by never toggling it faster than every few cycles. The bench changes every input on the falling edge, away from the sampling edge, so the synchronizer latency of R8 is exact and can be checked to the cycle.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  // synchronized heartbeat: current level and a one-cycle toggle strobe
  typedef struct packed {
    logic level;
    logic toggled;
  } hb_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/wdt_hb_sync.sv
`timescale 1ns/1ps
module wdt_hb_sync #(
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hb_async,
  output wdt_pkg::hb_t hb
);

  logic [STAGES-1:0] chain;
  logic              last_level;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= hb_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], hb_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_level <= 1'b0;
    else        last_level <= chain[STAGES-1];
  end

  always_comb begin
    hb.level   = chain[STAGES-1];
    hb.toggled = chain[STAGES-1] ^ last_level;
  end

endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int TIMEOUT = 64,
  localparam int CW = wdt_pkg::cnt_width(TIMEOUT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  output logic [CW-1:0] cnt,
  output logic          expired
);

  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || clear)  cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

endmodule

// File: rtl/wdt_out_stage.sv
`timescale 1ns/1ps
module wdt_out_stage (
  input  logic expired,
  input  logic supply_ok,
  output logic wdo_n
);

  // a low supply wins over everything; otherwise low only on expiry
  always_comb begin
    wdo_n = supply_ok && !expired;
  end

endmodule

// File: rtl/wdt_edge_watchdog.sv
`timescale 1ns/1ps
module wdt_edge_watchdog #(
  parameter int TIMEOUT     = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CW = wdt_pkg::cnt_width(TIMEOUT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_in,
  input  logic mon_en,
  input  logic supply_ok,
  output logic wdo_n
);

  wdt_pkg::hb_t  hb;
  logic          hb_toggle;
  logic [CW-1:0] cnt;
  logic          expired;
  logic          hb_level_unused;

  wdt_hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .hb_async (hb_in),
    .hb       (hb)
  );

  assign hb_toggle       = hb.toggled;
  assign hb_level_unused = hb.level;

  wdt_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mon_en),
    .clear   (hb_toggle),
    .cnt     (cnt),
    .expired (expired)
  );

  wdt_out_stage u_out (
    .expired   (expired),
    .supply_ok (supply_ok),
    .wdo_n     (wdo_n)
  );

endmodule

// File: rtl/wdt_edge_watchdog_chk.sv
`timescale 1ns/1ps
module wdt_edge_watchdog_chk #(
  parameter int TIMEOUT = 64,
  localparam int CW = wdt_pkg::cnt_width(TIMEOUT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mon_en,
  input logic          supply_ok,
  input logic          wdo_n,
  input logic          hb_toggle,
  input logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT - 1);

  assert_fall_on_timeout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wdo_n) && supply_ok && $past(supply_ok)) |-> ($past(cnt) == LAST));

  assert_edge_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hb_toggle |=> (cnt == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  assert_low_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wdo_n);

  assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mon_en) && supply_ok) |-> wdo_n);

endmodule

bind wdt_edge_watchdog wdt_edge_watchdog_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mon_en    (mon_en),
  .supply_ok (supply_ok),
  .wdo_n     (wdo_n),
  .hb_toggle (hb_toggle),
  .cnt       (cnt)
);

// File: tb/sim_wdt_edge_watchdog.sv
`timescale 1ns/1ps
module sim_wdt_edge_watchdog;

  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n, hb_in, mon_en, supply_ok;
  logic wdo_n;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wdt_edge_watchdog #(.TIMEOUT(T)) u0 (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in),
    .mon_en(mon_en), .supply_ok(supply_ok), .wdo_n(wdo_n)
  );

  typedef struct packed {
    logic       hb;
    logic       en;
    logic       sup;
    logic [7:0] cyc;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 8'd15, 1'b1, 4'd1},  // R1 still high at T-1
    '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd1},  // R1 low at T
    '{1'b1, 1'b1, 1'b1, 8'd3,  1'b1, 4'd2},  // R2 rising edge clears
    '{1'b1, 1'b1, 1'b1, 8'd15, 1'b1, 4'd1},
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b0, 4'd1},
    '{1'b0, 1'b1, 1'b0, 8'd3,  1'b0, 4'd4},  // R4 falling edge, supply low
    '{1'b0, 1'b1, 1'b1, 8'd1,  1'b1, 4'd2},  // R2 falling edge cleared it
    '{1'b0, 1'b0, 1'b1, 8'd40, 1'b1, 4'd5},  // R5 disabled stays high
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 4'd5},  // R5 low-line indicator
    '{1'b0, 1'b1, 1'b1, 8'd15, 1'b1, 4'd7},  // R7 restart from zero
    '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd7}
  };

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic exp);
    total++;
    if (wdo_n !== exp) begin
      bad++;
      $display("FAIL %s: wdo_n=%b expected %b at %0t", req, wdo_n, exp, $time);
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hb_in = 1'b0; mon_en = 1'b1; supply_ok = 1'b1;
    @(negedge clk);
    step(3);
    check("R6 reset state", 1'b1);
    supply_ok = 1'b0; #1;
    check("R4 low supply in reset", 1'b0);
    supply_ok = 1'b1;
    step(1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      hb_in = VEC[i].hb; mon_en = VEC[i].en; supply_ok = VEC[i].sup;
      step(int'(VEC[i].cyc));
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
    end

    // R3: stays low while saturated
    step(50);
    check("R3 held low", 1'b0);

    // R8: edge takes effect on third rising edge
    hb_in = 1'b1;
    step(2);
    check("R8 not yet cleared", 1'b0);
    step(1);
    check("R8 cleared on third edge", 1'b1);

    // R2: steady heartbeat every 8 cycles never times out
    for (int k = 0; k < 20; k++) begin
      hb_in = ~hb_in;
      for (int c = 0; c < 8; c++) begin
        step(1);
        if (wdo_n !== 1'b1) check("R2 periodic heartbeat", 1'b1);
      end
    end
    total++;
    check("R2 periodic heartbeat end", 1'b1);

    // R4: immediate force low mid-count
    supply_ok = 1'b0; #1;
    check("R4 immediate low", 1'b0);
    supply_ok = 1'b1; #1;
    check("R4 release", 1'b1);

    // R6: reset while expired, then count from release
    hb_in = 1'b0;
    step(5);
    step(T + 4);
    check("R6 expired before reset", 1'b0);
    rst_n = 1'b0; #1;
    check("R6 async clear", 1'b1);
    step(3);
    rst_n = 1'b1;
    step(T - 1);
    check("R6 high at T-1 after release", 1'b1);
    step(1);
    check("R6 low at T after release", 1'b0);

    // R5: disable clears an expired output on the next edge
    mon_en = 1'b0;
    step(1);
    check("R5 disable clears", 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule